// File: doc/BRIEF.md
# Offset-Based Cycle Counter with Compare Interrupt

This block holds a 64-bit architectural cycle counter. Its count never stops: a free-running 63-bit counter advances on every clock, and the value software sees is that counter minus a stored offset. A software write does not load the running counter. It computes a new offset, so the visible count jumps to the written value and keeps advancing from there. The top bit of the 64-bit word is a privilege lock flag. When the flag is set, only privileged requesters may read the count.

A second register, the compare register, holds an interrupt-disable flag in bit 63 and a 63-bit match value in the low bits. When interrupts are enabled and the visible count equals the match value, the block raises a single interrupt pulse. Reads return their result one cycle after the request, together with a valid strobe and a fault flag for refused reads. A system that needs further counters of the same kind, such as a system-tick counter and its compare register, places more instances of this block.

Top module: `tick_timer`

## Requirements
- R1: After reset, a privileged read of the count returns bit 63 = 1 with the count in bits 62:0, and a read of the compare register returns 64'h8000_0000_0000_0000 (interrupt disabled, match value 0).
- R2: The visible count advances by exactly one per clock. A read requested at a clock edge returns the count held just before that edge on rdData, with rdValid high, in the following cycle.
- R3: A write to the count (wrSel = 0) makes the visible count equal to bits 62:0 of wrData in the cycle after the write edge. Counting then resumes from that value.
- R4: A count write copies bit 63 of wrData into the lock flag. Reads of the count return the lock flag in bit 63.
- R5: A count read with rdPriv = 0 while the lock flag is 1 returns all-zero data with rdFault = 1. With rdPriv = 1, or with the lock flag at 0, the read returns the count with rdFault = 0.
- R6: A write with wrSel = 1 loads the compare register: bit 63 is the interrupt-disable flag and bits 62:0 are the match value. A read with rdSel = 1 returns it unchanged, and is never refused.
- R7: intPulse is high for the one cycle after any cycle in which the interrupt-disable flag is 0 and the visible count equals the match value. Otherwise it is low.
- R8: The visible count wraps modulo 2^63: after 2^63-1 it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrSel | input | 1 | Write target: 0 = count, 1 = compare |
| wrData | input | 64 | Write value |
| rdEn | input | 1 | Read request |
| rdSel | input | 1 | Read target: 0 = count, 1 = compare |
| rdPriv | input | 1 | Requester is privileged |
| rdValid | output | 1 | Read result valid (one cycle after rdEn) |
| rdData | output | 64 | Read result |
| rdFault | output | 1 | Read refused by the lock flag |
| intPulse | output | 1 | Compare-match interrupt pulse |

## Verification
The count is read back to back after idle stretches and straight after writes of small, large and all-ones values. These reads separate an offset that is computed correctly from one that is off by one, and they show whether the count wraps. Count reads are issued in every combination of requester privilege and lock-flag value. This isolates the refusal path from the normal return. The compare register is armed a few cycles ahead of the current count, once enabled and once disabled, and the bench checks intPulse against its own model every cycle. This tells a single correctly timed pulse apart from a missing, early or ungated one.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Strobes issued by the control to the datapath for one cycle
  typedef struct packed {
    logic ldOffset;  // count write: recompute offset and lock flag
    logic ldCmp;     // compare register write
    logic rdCnt;     // return the visible count
    logic rdCmp;     // return the compare register
    logic rdDeny;    // refuse a count read (zero data, fault)
  } tickStrobe_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic        rdEn,
  input  logic        rdSel,
  input  logic        rdPriv,
  input  logic        nptQ,
  output tickStrobe_t strobe
);
  logic cntRead;

  always_comb begin
    cntRead         = rdEn & ~rdSel;
    strobe.ldOffset = wrEn & ~wrSel;
    strobe.ldCmp    = wrEn & wrSel;
    strobe.rdCmp    = rdEn & rdSel;
    strobe.rdDeny   = cntRead & ~rdPriv & nptQ;
    strobe.rdCnt    = cntRead & (rdPriv | ~nptQ);
  end

  // R5: at most one kind of read result is chosen per request
  p_one_read_kind_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdCnt, strobe.rdCmp, strobe.rdDeny}));

  // R5: a privileged requester is never refused
  p_priv_not_denied_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdPriv) |-> !strobe.rdDeny);
endmodule

// File: rtl/tick_dp.sv
module tick_dp
  import tick_pkg::*;
#(
  parameter int CNT_W  = 63,
  localparam int WORD_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tickStrobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  output logic              nptQ,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              rdFault,
  output logic              intPulse
);
  logic [CNT_W-1:0] cycCnt;
  logic [CNT_W-1:0] offsetQ;
  logic [CNT_W-1:0] cmpVal;
  logic             cmpDis;
  logic [CNT_W-1:0] visCnt;
  logic [CNT_W-1:0] cycNext;
  logic             armed;

  always_comb begin
    visCnt  = cycCnt - offsetQ;
    cycNext = cycCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt   <= '0;
      offsetQ  <= '0;
      nptQ     <= 1'b1;
      cmpDis   <= 1'b1;
      cmpVal   <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
      rdFault  <= 1'b0;
      intPulse <= 1'b0;
      armed    <= 1'b0;
    end else begin
      armed  <= 1'b1;
      cycCnt <= cycNext;
      if (strobe.ldOffset) begin
        // Offset is taken against the post-edge count, so the write is visible at once
        offsetQ <= cycNext - wrData[CNT_W-1:0];
        nptQ    <= wrData[CNT_W];
      end
      if (strobe.ldCmp) begin
        cmpDis <= wrData[CNT_W];
        cmpVal <= wrData[CNT_W-1:0];
      end
      rdValid <= strobe.rdCnt | strobe.rdCmp | strobe.rdDeny;
      rdFault <= strobe.rdDeny;
      if (strobe.rdCnt)      rdData <= {nptQ, visCnt};
      else if (strobe.rdCmp) rdData <= {cmpDis, cmpVal};
      else                   rdData <= '0;
      intPulse <= ~cmpDis & (visCnt == cmpVal);
    end
  end

  // R2: without a count write the visible count steps by one
  p_count_steps_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(strobe.ldOffset)) |-> (visCnt == $past(visCnt) + 1'b1));

  // R3: a count write makes the written value visible on the next cycle
  p_write_visible_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldOffset |=> (visCnt == $past(wrData[CNT_W-1:0])));

  // R4: the lock flag follows bit 63 of a count write
  p_lock_from_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldOffset |=> (nptQ == $past(wrData[CNT_W])));

  // R5: a refused read carries zero data and is flagged valid
  p_fault_zero_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdFault |-> (rdValid && rdData == '0));

  // R7: a pulse needs interrupts enabled in the cycle before
  p_pulse_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && intPulse) |-> !$past(cmpDis));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W  = 63,
  localparam int WORD_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rdSel,
  input  logic              rdPriv,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              rdFault,
  output logic              intPulse
);
  tickStrobe_t strobe;
  logic        nptQ;

  tick_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .rdEn   (rdEn),
    .rdSel  (rdSel),
    .rdPriv (rdPriv),
    .nptQ   (nptQ),
    .strobe (strobe)
  );

  tick_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .nptQ     (nptQ),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .rdFault  (rdFault),
    .intPulse (intPulse)
  );
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int CNT_W = 63;
  localparam int WORD_W = CNT_W + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              wrSel = 1'b0;
  logic [WORD_W-1:0] wrData = '0;
  logic              rdEn = 1'b0;
  logic              rdSel = 1'b0;
  logic              rdPriv = 1'b0;
  logic              rdValid;
  logic [WORD_W-1:0] rdData;
  logic              rdFault;
  logic              intPulse;

  always #2ns clk = ~clk;  // 250 MHz

  tick_timer #(.CNT_W(CNT_W)) i_tick_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdEn(rdEn), .rdSel(rdSel), .rdPriv(rdPriv), .rdValid(rdValid),
    .rdData(rdData), .rdFault(rdFault), .intPulse(intPulse)
  );

  typedef struct {
    logic [WORD_W-1:0] data;
    logic              fault;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];
  int errors = 0;
  int checks = 0;
  int pulseCount = 0;

  // Reference state, built from the requirements
  logic [CNT_W-1:0] mCnt = '0;
  logic             mLock = 1'b1;
  logic             mDis = 1'b1;
  logic [CNT_W-1:0] mCmp = '0;
  logic             mIntExp = 1'b0;

  always @(posedge clk) begin
    if (rstN) begin
      mIntExp = !mDis && (mCnt == mCmp);  // R7 uses pre-edge state
      if (wrEn && !wrSel) begin
        mCnt  = wrData[CNT_W-1:0];
        mLock = wrData[CNT_W];
      end else begin
        mCnt = mCnt + 1'b1;                 // R8 wraps naturally at 63 bits
      end
      if (wrEn && wrSel) begin
        mDis = wrData[CNT_W];
        mCmp = wrData[CNT_W-1:0];
      end
    end
  end

  // Monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected rdValid data=%h", rdData);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          if (rdData !== e.data || rdFault !== e.fault) begin
            errors++;
            $display("FAIL %s: got data=%h fault=%b, expected data=%h fault=%b",
                     e.tag, rdData, rdFault, e.data, e.fault);
          end
        end
      end
      checks++;
      if (intPulse !== mIntExp) begin
        errors++;
        $display("FAIL R7: intPulse=%b expected %b", intPulse, mIntExp);
      end
      if (intPulse === 1'b1) pulseCount++;
    end
  end

  task automatic doRead(input logic sel, input logic priv, input string tag);
    expItem_t e;
    rdEn = 1'b1; rdSel = sel; rdPriv = priv;
    e.tag = tag;
    if (sel) begin
      e.data = {mDis, mCmp}; e.fault = 1'b0;
    end else if (!priv && mLock) begin
      e.data = '0; e.fault = 1'b1;
    end else begin
      e.data = {mLock, mCnt}; e.fault = 1'b0;
    end
    expQ.push_back(e);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doWrite(input logic sel, input logic [WORD_W-1:0] val);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkPulses(input int want, input string tag);
    checks++;
    if (pulseCount != want) begin
      errors++;
      $display("FAIL %s: pulse count %0d expected %0d", tag, pulseCount, want);
    end
  endtask

  initial begin
    #400us;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    doRead(1'b0, 1'b1, "R1");
    doRead(1'b1, 1'b0, "R1");
    // R2 back-to-back and after idle
    idle(5);
    doRead(1'b0, 1'b1, "R2");
    doRead(1'b0, 1'b1, "R2");
    idle(7);
    doRead(1'b0, 1'b1, "R2");
    // R5 refused while locked
    doRead(1'b0, 1'b0, "R5");
    // R3/R4 write count unlocked
    doWrite(1'b0, 64'd1000);
    doRead(1'b0, 1'b0, "R3");
    idle(4);
    doRead(1'b0, 1'b0, "R5");
    doRead(1'b0, 1'b1, "R3");
    // R4 relock with a write
    doWrite(1'b0, {1'b1, 63'd5});
    doRead(1'b0, 1'b0, "R4");
    doRead(1'b0, 1'b1, "R4");
    // R8 wrap
    doWrite(1'b0, {1'b0, {CNT_W{1'b1}}});
    doRead(1'b0, 1'b0, "R8");
    doRead(1'b0, 1'b0, "R8");
    // R6 compare register
    doWrite(1'b1, {1'b1, 63'd123});
    doRead(1'b1, 1'b0, "R6");
    doRead(1'b1, 1'b1, "R6");
    // R7 enabled match
    pulseCount = 0;
    doWrite(1'b1, {1'b0, mCnt + 63'd10});
    idle(20);
    checkPulses(1, "R7");
    // R7 disabled match
    pulseCount = 0;
    doWrite(1'b1, {1'b1, mCnt + 63'd5});
    idle(15);
    checkPulses(0, "R7");
    doRead(1'b1, 1'b0, "R6");
    idle(3);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d reads never returned, expected 0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule